// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every physical memory access, whether the access may go ahead. It holds a bank of programmable protection regions. Each region has an 8-bit configuration byte and an address register that stores the address bits above the 4-byte granule. A checking port is purely combinational. It takes a byte address, an access kind (load, store or instruction fetch) and the privilege level of the requester. It returns a single fault flag. Translation, caching and trap delivery are handled elsewhere. The block only raises the flag.

A region can match in one of three ways. It can match one aligned 4-byte word. It can match any naturally aligned power-of-two block, whose size is encoded by the trailing ones of its address register. It can match a base-and-bounds window, using the address register of the entry below it as the inclusive base and its own address register as the exclusive top. When several regions match, the lowest-numbered one decides. Locking a region freezes it until reset, and also subjects machine-level accesses to its permissions.

Configuration and address registers are written through two single-cycle write strobes. A write lands at the next rising clock edge, and the check port sees the new value straight after that edge.

Top module: `pmp_checker`

## Requirements
- R1: After reset every region is disabled and unlocked. A below-machine access then faults, and a machine access is allowed.
- R2: Configuration byte layout: bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match kind (0 disabled, 1 base-and-bounds, 2 single word, 3 power-of-two) and bit 7 is the lock. The access kind code is 0 load, 1 store, 2 fetch and 3 reserved; the reserved code is granted by no region. Privilege code 3 is machine; codes 0, 1 and 2 are below machine.
- R3: In single-word mode a region matches exactly the four bytes whose address bits above bit 1 equal its address register.
- R4: In power-of-two mode, an address register ending in t ones covers 2^(t+3) bytes, aligned to that size. The base is the register with those t ones cleared, shifted left by two.
- R5: In base-and-bounds mode, entry i matches word addresses w with prev <= w < cur. Here cur is entry i's register, and prev is entry i-1's register, or zero for entry 0.
- R6: When several regions match, the lowest-numbered matching region alone decides the result.
- R7: A below-machine access that matches no region faults. One that matches a region faults unless that region grants the requested kind.
- R8: A machine access is allowed when it matches no region or its deciding region is unlocked. When its deciding region is locked, the access faults unless that region grants the kind.
- R9: While a region's lock bit is set, writes to its configuration byte and to its address register are ignored. Only reset clears the lock.
- R10: While region i+1 is locked in base-and-bounds mode, writes to region i's address register are ignored.
- R11: A register write takes effect at the next rising clock edge. The fault flag follows the check inputs in the same cycle without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_idx | input | IDX_W (4) | Region selected for configuration write |
| cfg_wdata | input | 8 | Configuration byte to write |
| adr_we | input | 1 | Address register write strobe |
| adr_idx | input | IDX_W (4) | Region selected for address write |
| adr_wdata | input | PADDR_W-2 (30) | Address register value (byte address bits above bit 1) |
| chk_addr | input | PADDR_W (32) | Byte address of the access being checked |
| chk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| chk_priv | input | 2 | Requester privilege: 3 machine, others below machine |
| chk_fault | output | 1 | High when the access must be refused |

## Verification
The bench probes the edges of every region: the last word inside and the first word outside a power-of-two block and a single-word region, and both sides of the inclusive base and exclusive top of a base-and-bounds window. A design with an off-by-one size or an inclusive top would grant or refuse exactly those words. It overlaps two regions with opposite permissions. A design that picked the highest match, or merged permissions, would let the shadowed word through. It locks regions and then tries to rewrite them and the base of a locked window. A design that missed either lock path would change what later probes return. It also checks that machine accesses become bound only by locked regions. Random writes and probes across a small address window are compared against a reference model built into the bench.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    // Configuration byte field positions
    localparam int CFG_R_BIT    = 0;
    localparam int CFG_W_BIT    = 1;
    localparam int CFG_X_BIT    = 2;
    localparam int CFG_MODE_LO  = 3;
    localparam int CFG_LOCK_BIT = 7;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_RANGE = 2'd1,
        MATCH_WORD  = 2'd2,
        MATCH_POW2  = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [1:0] PRIV_MACHINE = 2'd3;

    function automatic match_mode_e cfg_mode(input logic [7:0] cfg);
        return match_mode_e'(cfg[CFG_MODE_LO +: 2]);
    endfunction

endpackage

// File: rtl/pmp_regfile.sv
module pmp_regfile
    import pmp_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4,
    parameter int WA    = 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [7:0]           cfg_wdata,
    input  logic                 adr_we,
    input  logic [IDX_W-1:0]     adr_idx,
    input  logic [WA-1:0]        adr_wdata,
    output logic [N-1:0][7:0]    cfg_q,
    output logic [N-1:0][WA-1:0] adr_q
);

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic [7:0]    cfg_r;
        logic [WA-1:0] adr_r;
        logic          cfg_frozen;
        logic          adr_frozen;

        assign cfg_frozen = cfg_r[CFG_LOCK_BIT];

        if (i + 1 < N) begin : g_upper
            // a locked range entry above also pins this entry's base
            assign adr_frozen = cfg_r[CFG_LOCK_BIT] |
                                (cfg_q[i+1][CFG_LOCK_BIT] &&
                                 cfg_mode(cfg_q[i+1]) == MATCH_RANGE);
        end else begin : g_top
            assign adr_frozen = cfg_r[CFG_LOCK_BIT];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_r <= '0;
            end else if (cfg_we && cfg_idx == IDX_W'(i) && !cfg_frozen) begin
                cfg_r <= cfg_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                adr_r <= '0;
            end else if (adr_we && adr_idx == IDX_W'(i) && !adr_frozen) begin
                adr_r <= adr_wdata;
            end
        end

        assign cfg_q[i] = cfg_r;
        assign adr_q[i] = adr_r;
    end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
    import pmp_pkg::*;
#(
    parameter int WA = 30
) (
    input  logic [WA-1:0] word_addr,
    input  logic [WA-1:0] cur_addr,
    input  logic [WA-1:0] prev_addr,
    input  match_mode_e   mode,
    output logic          hit
);

    logic [WA-1:0] pow2_mask;

    // low bits that vary inside the block: trailing ones plus one
    assign pow2_mask = cur_addr ^ (cur_addr + WA'(1));

    always_comb begin
        unique case (mode)
            MATCH_OFF:   hit = 1'b0;
            MATCH_RANGE: hit = (word_addr >= prev_addr) && (word_addr < cur_addr);
            MATCH_WORD:  hit = (word_addr == cur_addr);
            MATCH_POW2:  hit = ((word_addr ^ cur_addr) & ~pow2_mask) == '0;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_arbiter.sv
module pmp_arbiter
    import pmp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]      hit,
    input  logic [N-1:0][7:0] cfg_q,
    input  acc_kind_e         kind,
    input  logic [1:0]        priv,
    output logic              fault
);

    logic       any_hit;
    logic [7:0] win_cfg;
    logic       granted;
    logic       is_machine;

    always_comb begin
        any_hit = 1'b0;
        win_cfg = '0;
        // scan downward so the lowest index is written last and wins
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit = 1'b1;
                win_cfg = cfg_q[i];
            end
        end
    end

    always_comb begin
        unique case (kind)
            ACC_LOAD:  granted = win_cfg[CFG_R_BIT];
            ACC_STORE: granted = win_cfg[CFG_W_BIT];
            ACC_FETCH: granted = win_cfg[CFG_X_BIT];
            ACC_RSVD:  granted = 1'b0;
            default:   granted = 1'b0;
        endcase
    end

    assign is_machine = (priv == PRIV_MACHINE);

    always_comb begin
        if (!any_hit) begin
            fault = !is_machine;
        end else if (is_machine && !win_cfg[CFG_LOCK_BIT]) begin
            fault = 1'b0;
        end else begin
            fault = !granted;
        end
    end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int PADDR_W     = 32,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int WORD_W     = PADDR_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [7:0]         cfg_wdata,
    input  logic               adr_we,
    input  logic [IDX_W-1:0]   adr_idx,
    input  logic [WORD_W-1:0]  adr_wdata,
    input  logic [PADDR_W-1:0] chk_addr,
    input  logic [1:0]         chk_kind,
    input  logic [1:0]         chk_priv,
    output logic               chk_fault
);

    logic [NUM_REGIONS-1:0][7:0]        cfg_q;
    logic [NUM_REGIONS-1:0][WORD_W-1:0] adr_q;
    logic [NUM_REGIONS-1:0]             hit;
    logic [WORD_W-1:0]                  word_addr;

    assign word_addr = chk_addr[PADDR_W-1:2];

    pmp_regfile #(
        .N     (NUM_REGIONS),
        .IDX_W (IDX_W),
        .WA    (WORD_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .adr_we    (adr_we),
        .adr_idx   (adr_idx),
        .adr_wdata (adr_wdata),
        .cfg_q     (cfg_q),
        .adr_q     (adr_q)
    );

    for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_match
        logic [WORD_W-1:0] prev;
        if (i == 0) begin : g_first
            assign prev = '0;
        end else begin : g_rest
            assign prev = adr_q[i-1];
        end

        pmp_region_match #(
            .WA (WORD_W)
        ) u_match (
            .word_addr (word_addr),
            .cur_addr  (adr_q[i]),
            .prev_addr (prev),
            .mode      (cfg_mode(cfg_q[i])),
            .hit       (hit[i])
        );
    end

    pmp_arbiter #(
        .N (NUM_REGIONS)
    ) u_arb (
        .hit   (hit),
        .cfg_q (cfg_q),
        .kind  (acc_kind_e'(chk_kind)),
        .priv  (chk_priv),
        .fault (chk_fault)
    );

endmodule

// File: rtl/pmp_checker_props.sv
module pmp_checker_props #(
    parameter int N  = 16,
    parameter int WA = 30
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           chk_priv,
    input logic                 chk_fault,
    input logic [N-1:0][7:0]    cfg_q,
    input logic [N-1:0][WA-1:0] adr_q
);

    logic [N-1:0] lock_vec;
    logic [N-1:0] live_vec;

    for (genvar i = 0; i < N; i++) begin : g_vec
        assign lock_vec[i] = cfg_q[i][7];
        assign live_vec[i] = cfg_q[i][4:3] != 2'd0;
    end

    for (genvar i = 0; i < N; i++) begin : g_hold
        // R9
        cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[i][7] |=> $stable(cfg_q[i]));

        // R9
        adr_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_q[i][7] |=> $stable(adr_q[i]));

        if (i + 1 < N) begin : g_base
            // R10
            range_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q[i+1][7] && cfg_q[i+1][4:3] == 2'd1) |=> $stable(adr_q[i]));
        end
    end

    // R8
    machine_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_priv == 2'd3 && lock_vec == '0) |-> !chk_fault);

    // R7
    lower_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_priv != 2'd3 && live_vec == '0) |-> chk_fault);

endmodule

bind pmp_checker pmp_checker_props #(
    .N  (NUM_REGIONS),
    .WA (WORD_W)
) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_priv  (chk_priv),
    .chk_fault (chk_fault),
    .cfg_q     (cfg_q),
    .adr_q     (adr_q)
);

// File: tb/pmp_checker_test.sv
`timescale 1ns/1ps
module pmp_checker_test;

    localparam int N  = 16;
    localparam int AW = 32;
    localparam int WA = AW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_idx = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          adr_we = 1'b0;
    logic [3:0]    adr_idx = '0;
    logic [WA-1:0] adr_wdata = '0;
    logic [AW-1:0] chk_addr = '0;
    logic [1:0]    chk_kind = '0;
    logic [1:0]    chk_priv = '0;
    logic          chk_fault;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0]    m_cfg [N];
    logic [WA-1:0] m_adr [N];

    always #5 clk = ~clk;

    pmp_checker uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .adr_we(adr_we), .adr_idx(adr_idx), .adr_wdata(adr_wdata),
        .chk_addr(chk_addr), .chk_kind(chk_kind), .chk_priv(chk_priv),
        .chk_fault(chk_fault)
    );

    function automatic void model_clear();
        for (int i = 0; i < N; i++) begin
            m_cfg[i] = '0;
            m_adr[i] = '0;
        end
    endfunction

    function automatic bit model_hit(int i, logic [WA-1:0] w);
        logic [WA-1:0] cur = m_adr[i];
        logic [WA-1:0] prev = (i == 0) ? '0 : m_adr[i-1];
        int t = 0;
        case (m_cfg[i][4:3])
            2'd1: return (w >= prev) && (w < cur);
            2'd2: return w == cur;
            2'd3: begin
                while (t < WA && cur[t]) t++;
                if (t + 1 >= WA) return 1'b1;
                return (w >> (t + 1)) == (cur >> (t + 1));
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit model_fault(logic [AW-1:0] a, int k, int p);
        logic [WA-1:0] w = a[AW-1:2];
        bit perm;
        for (int i = 0; i < N; i++) begin
            if (model_hit(i, w)) begin
                perm = (k < 3) ? m_cfg[i][k] : 1'b0;
                if (p == 3 && !m_cfg[i][7]) return 1'b0;
                return !perm;
            end
        end
        return p != 3;
    endfunction

    task automatic wr_cfg(int idx, logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = v;
        if (!m_cfg[idx][7]) m_cfg[idx] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_adr(int idx, logic [WA-1:0] v);
        bit frozen = m_cfg[idx][7];
        if (idx + 1 < N && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'd1) frozen = 1;
        @(negedge clk);
        adr_we = 1'b1; adr_idx = 4'(idx); adr_wdata = v;
        if (!frozen) m_adr[idx] = v;
        @(negedge clk);
        adr_we = 1'b0;
    endtask

    task automatic probe(logic [AW-1:0] a, int k, int p, string req);
        bit exp;
        chk_addr = a; chk_kind = 2'(k); chk_priv = 2'(p);
        #1;
        exp = model_fault(a, k, p);
        checks++;
        if (chk_fault !== exp) begin
            failures++;
            $display("FAIL %s addr=%h kind=%0d priv=%0d actual=%b expected=%b",
                     req, a, k, p, chk_fault, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        probe(32'h0000_0000, 0, 0, "R1");
        probe(32'h8000_1234, 2, 1, "R1");
        probe(32'h0000_0000, 1, 3, "R1");

        // R3 single word, R2 field layout: entry0 read only at 0x1000
        wr_adr(0, WA'(32'h1000 >> 2));
        wr_cfg(0, 8'b000_10_001);
        probe(32'h0000_1000, 0, 0, "R3");
        probe(32'h0000_1003, 0, 0, "R3");
        probe(32'h0000_1004, 0, 0, "R3");
        probe(32'h0000_0FFC, 0, 0, "R3");
        probe(32'h0000_1000, 1, 0, "R2");

        // R4 power-of-two 32 bytes at 0x2000, execute only (R11 write lands next edge)
        wr_adr(1, WA'((32'h2000 >> 2) | 32'h3));
        wr_cfg(1, 8'b000_11_100);
        probe(32'h0000_2000, 2, 1, "R4");
        probe(32'h0000_201C, 2, 1, "R4");
        probe(32'h0000_2020, 2, 1, "R4");
        probe(32'h0000_1FFC, 2, 1, "R4");
        probe(32'h0000_2000, 0, 1, "R2");

        // R5 range [0x3000,0x3100) via entries 2 and 3
        wr_adr(2, WA'(32'h3000 >> 2));
        wr_adr(3, WA'(32'h3100 >> 2));
        wr_cfg(3, 8'b000_01_011);
        probe(32'h0000_3000, 1, 0, "R5");
        probe(32'h0000_30FC, 0, 0, "R5");
        probe(32'h0000_3100, 0, 0, "R5");
        probe(32'h0000_2FFC, 0, 0, "R5");

        // R6 priority: entry4 word 0x4000 no perms, entry5 pow2 64B all perms
        wr_adr(4, WA'(32'h4000 >> 2));
        wr_cfg(4, 8'b000_10_000);
        wr_adr(5, WA'((32'h4000 >> 2) | 32'h7));
        wr_cfg(5, 8'b000_11_111);
        probe(32'h0000_4000, 0, 0, "R6");
        probe(32'h0000_4004, 0, 0, "R6");
        probe(32'h0000_403C, 1, 0, "R6");
        // R2 reserved kind never granted
        probe(32'h0000_4004, 3, 0, "R2");
        // R7 unmatched lower access
        probe(32'h0000_7000, 0, 1, "R7");

        // R8 machine through unlocked no-perm entry, then locked
        probe(32'h0000_4000, 0, 3, "R8");
        wr_cfg(4, 8'b100_10_000);
        probe(32'h0000_4000, 0, 3, "R8");
        probe(32'h0000_4004, 0, 3, "R8");
        probe(32'h0000_7000, 1, 3, "R8");

        // R9 locked entry ignores rewrites
        wr_cfg(4, 8'b000_10_111);
        wr_adr(4, WA'(32'h6000 >> 2));
        probe(32'h0000_4000, 0, 0, "R9");
        probe(32'h0000_6000, 0, 0, "R9");

        // R10 locked range pins lower base
        wr_adr(6, WA'(32'h5000 >> 2));
        wr_adr(7, WA'(32'h5100 >> 2));
        wr_cfg(7, 8'b100_01_001);
        wr_adr(6, WA'(32'h5080 >> 2));
        probe(32'h0000_5000, 0, 0, "R10");
        probe(32'h0000_5040, 0, 3, "R10");
        wr_adr(7, WA'(32'h5200 >> 2));
        probe(32'h0000_5100, 0, 0, "R9");

        // R1 R9 reset releases locks
        do_reset();
        probe(32'h0000_4000, 0, 3, "R1");
        probe(32'h0000_5000, 0, 0, "R1");
        wr_cfg(4, 8'b000_10_111);
        wr_adr(4, WA'(32'h4000 >> 2));
        probe(32'h0000_4000, 1, 0, "R9");

        // Random mix, R6 R7 R8 R9 R10 against the model
        do_reset();
        for (int it = 0; it < 400; it++) begin
            int idx = $urandom_range(0, N - 1);
            logic [7:0] c = 8'($urandom());
            if ($urandom_range(0, 7) != 0) c[7] = 1'b0;
            c[6:5] = 2'b00;
            if ($urandom_range(0, 1) == 0) wr_cfg(idx, c);
            else wr_adr(idx, WA'($urandom_range(0, 1023)));
            for (int j = 0; j < 4; j++) begin
                probe(32'($urandom_range(0, 4095)), $urandom_range(0, 3),
                      $urandom_range(0, 3), "R6_R7_R8_R9_R10");
            end
            if (it % 100 == 99) do_reset();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule